// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 18-bit words, written from one clock domain and read from another. Write and read requests are active low. Five active-low status outputs report empty, full, more than half full, nearly empty and nearly full. The two "nearly" thresholds are held in offset registers. These registers are loaded from the write data bus and read back on the output bus while a load control is held low.

A retransmit strobe on the read side moves the read position back to storage location zero. The words written since reset can then be replayed. A mode input chooses how the two threshold flags are produced. In one mode they are registered in their own clock domain. In the other they are combinational, taken from the live pointers of both domains. The read and write pointers cross domains as Gray code through two-flop synchronizers. Reset is asserted asynchronously and released synchronously in each domain.

Top module: `prog_flag_fifo`

## Requirements
- R1: On a rising `wclk` edge with `wr_n` low, `ld_n` high and `full_n` high, `din` is stored. Words come out in the order they were stored.
- R2: A write attempted while `full_n` is low stores nothing. The stored words and the write pointer are unchanged.
- R3: On a rising `rclk` edge with `rd_n` low, `ld_n` high, `rt_n` high and `empty_n` high, the next word appears on `dout` one edge later. In every other case `dout` holds its value, including a read attempted while empty.
- R4: `empty_n` is low while no unread word is visible to the read domain, and it is generated in the `rclk` domain. `full_n` is low while DEPTH words are held, and it is generated in the `wclk` domain.
- R5: `half_n` is low while more than DEPTH/2 words are held, as seen by the write domain.
- R6: `aempty_n` is low when the fill level is at or below the near-empty offset. `afull_n` is low when the free space is at or below the near-full offset. Both offsets reset to 7.
- R7: With `sync_mode` high, the two threshold flags are registered on their own clock. With `sync_mode` low, they are combinational from the live pointers. Once the FIFO is idle, both modes give the same values.
- R8: A `wclk` edge with `ld_n` low and `wr_n` low writes `din[AW-1:0]` into the offset register chosen by a write index. Index 0 is near-empty and index 1 is near-full. The index toggles after each load. Storage is not written, even when the FIFO is full.
- R9: An `rclk` edge with `ld_n` low and `rd_n` low places the offset chosen by a separate read-back index on `dout`, zero-extended. The order is the same: near-empty, then near-full, then wrapping. The data read pointer does not move.
- R10: An `rclk` edge with `rt_n` low sets the read pointer to location 0. It takes priority over a data read on the same edge, and `dout` holds on that edge.
- R11: After reset, `empty_n`=0, `full_n`=1, `half_n`=1, `aempty_n`=0, `afull_n`=1 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 18 | Write data or offset value |
| wr_n | input | 1 | Write request, active low |
| rd_n | input | 1 | Read request, active low |
| ld_n | input | 1 | Offset register access, active low |
| rt_n | input | 1 | Retransmit strobe, active low, sampled on `rclk` |
| sync_mode | input | 1 | 1: registered threshold flags, 0: combinational |
| dout | output | 18 | Read data or offset read-back |
| empty_n | output | 1 | Empty, active low |
| full_n | output | 1 | Full, active low |
| half_n | output | 1 | More than half full, active low |
| aempty_n | output | 1 | At or below the near-empty threshold, active low |
| afull_n | output | 1 | At or below the near-full free-space threshold, active low |

## Verification
A retransmit and a data read can fall on the same read-clock edge. The bench drives both `rt_n` and `rd_n` low on one edge after the FIFO has been drained. It judges the outcome in three ways. `dout` must keep the last word drained. `empty_n` must rise once the rewind is visible. The following reads must replay the stored words from location 0 in order. The bench also sweeps every fill level from 0 to DEPTH on a 16-deep instance and computes all five flags arithmetically at each level, alternating the flag mode.

// File: rtl/prog_fifo_pkg.sv
package prog_fifo_pkg;
  localparam int WORD_W = 18;

  typedef enum logic {
    OFS_NEAR_EMPTY = 1'b0,
    OFS_NEAR_FULL  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/fifo_cdc_sync.sv
module fifo_cdc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int W     = 18,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/fifo_wside.sv
module fifo_wside
  import prog_fifo_pkg::*;
#(
  parameter int W         = 18,
  parameter int DEPTH     = 2048,
  parameter int RESET_OFS = 7,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          ld_n,
  input  logic [W-1:0]  din,
  input  logic          sync_mode,
  input  logic [PW-1:0] rgray_sync,
  input  logic [PW-1:0] rptr_live,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          half_n,
  output logic          afull_n,
  output logic [AW-1:0] ne_ofs,
  output logic [AW-1:0] nf_ofs
);
  localparam logic [PW-1:0] LVL_FULL = PW'(DEPTH);
  localparam logic [PW-1:0] LVL_HALF = PW'(DEPTH / 2);
  localparam logic [AW-1:0] OFS_RST  = AW'(RESET_OFS);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wptr_q, wptr_d, wgray_q, wgray_d;
  logic [AW-1:0] ne_q, ne_d, nf_q, nf_d;
  ofs_sel_e      widx_q, widx_d;
  logic          nf_flag_q, nf_flag_d;
  logic [PW-1:0] rptr_sync, fill, fill_live, room, room_live;
  logic          is_full, do_wr, do_ld;

  assign rptr_sync = g2b(rgray_sync);
  assign fill      = wptr_q - rptr_sync;
  assign fill_live = wptr_q - rptr_live;
  assign room      = LVL_FULL - fill;
  assign room_live = LVL_FULL - fill_live;
  assign is_full   = (fill == LVL_FULL);
  assign do_wr     = !wr_n && ld_n && !is_full;
  assign do_ld     = !wr_n && !ld_n;

  always_comb begin
    wptr_d    = wptr_q;
    wgray_d   = wgray_q;
    ne_d      = ne_q;
    nf_d      = nf_q;
    widx_d    = widx_q;
    nf_flag_d = (room <= {1'b0, nf_q});
    if (do_wr) begin
      wptr_d  = wptr_q + 1'b1;
      wgray_d = wptr_d ^ (wptr_d >> 1);
    end
    if (do_ld) begin
      if (widx_q == OFS_NEAR_EMPTY) ne_d = din[AW-1:0];
      else                          nf_d = din[AW-1:0];
      widx_d = (widx_q == OFS_NEAR_EMPTY) ? OFS_NEAR_FULL : OFS_NEAR_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      wgray_q   <= '0;
      ne_q      <= OFS_RST;
      nf_q      <= OFS_RST;
      widx_q    <= OFS_NEAR_EMPTY;
      nf_flag_q <= 1'b0;
    end else begin
      if (do_wr) begin
        wptr_q  <= wptr_d;
        wgray_q <= wgray_d;
      end
      if (do_ld) begin
        ne_q   <= ne_d;
        nf_q   <= nf_d;
        widx_q <= widx_d;
      end
      nf_flag_q <= nf_flag_d;
    end
  end

  assign mem_we    = do_wr;
  assign mem_waddr = wptr_q[AW-1:0];
  assign wptr      = wptr_q;
  assign wgray     = wgray_q;
  assign full_n    = !is_full;
  assign half_n    = !(fill > LVL_HALF);
  assign afull_n   = sync_mode ? !nf_flag_q : !(room_live <= {1'b0, nf_q});
  assign ne_ofs    = ne_q;
  assign nf_ofs    = nf_q;
endmodule

// File: rtl/fifo_rside.sv
module fifo_rside
  import prog_fifo_pkg::*;
#(
  parameter int W     = 18,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_n,
  input  logic          ld_n,
  input  logic          rt_n,
  input  logic          sync_mode,
  input  logic [PW-1:0] wgray_sync,
  input  logic [PW-1:0] wptr_live,
  input  logic [W-1:0]  mem_rdata,
  input  logic [AW-1:0] ne_ofs,
  input  logic [AW-1:0] nf_ofs,
  output logic [AW-1:0] mem_raddr,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] rgray,
  output logic [W-1:0]  dout,
  output logic          empty_n,
  output logic          aempty_n
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rptr_q, rptr_d, rgray_q, rgray_d;
  logic [W-1:0]  dout_q, dout_d;
  ofs_sel_e      ridx_q, ridx_d;
  logic          ne_flag_q, ne_flag_d;
  logic [PW-1:0] wptr_sync, level, level_live;
  logic [AW-1:0] ofs_pick;
  logic          is_empty, do_rt, do_rd, do_lrd, ptr_en, dout_en;

  assign wptr_sync  = g2b(wgray_sync);
  assign level      = wptr_sync - rptr_q;
  assign level_live = wptr_live - rptr_q;
  assign is_empty   = (level == '0);
  assign do_rt      = !rt_n;
  assign do_rd      = !rd_n && ld_n && !is_empty && !do_rt;
  assign do_lrd     = !rd_n && !ld_n;
  assign ptr_en     = do_rt || do_rd;
  assign dout_en    = do_rd || do_lrd;
  assign ofs_pick   = (ridx_q == OFS_NEAR_EMPTY) ? ne_ofs : nf_ofs;

  always_comb begin
    rptr_d    = rptr_q;
    dout_d    = dout_q;
    ridx_d    = ridx_q;
    ne_flag_d = (level <= {1'b0, ne_ofs});
    if (do_rt)      rptr_d = '0;
    else if (do_rd) rptr_d = rptr_q + 1'b1;
    rgray_d = rptr_d ^ (rptr_d >> 1);
    if (do_lrd) begin
      dout_d = {{(W-AW){1'b0}}, ofs_pick};
      ridx_d = (ridx_q == OFS_NEAR_EMPTY) ? OFS_NEAR_FULL : OFS_NEAR_EMPTY;
    end else if (do_rd) begin
      dout_d = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q    <= '0;
      rgray_q   <= '0;
      dout_q    <= '0;
      ridx_q    <= OFS_NEAR_EMPTY;
      ne_flag_q <= 1'b1;
    end else begin
      if (ptr_en) begin
        rptr_q  <= rptr_d;
        rgray_q <= rgray_d;
      end
      if (dout_en) dout_q <= dout_d;
      if (do_lrd)  ridx_q <= ridx_d;
      ne_flag_q <= ne_flag_d;
    end
  end

  assign mem_raddr = rptr_q[AW-1:0];
  assign rptr      = rptr_q;
  assign rgray     = rgray_q;
  assign dout      = dout_q;
  assign empty_n   = !is_empty;
  assign aempty_n  = sync_mode ? !ne_flag_q : !(level_live <= {1'b0, ne_ofs});
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import prog_fifo_pkg::*;
#(
  parameter int WIDTH     = WORD_W,
  parameter int DEPTH     = 2048,
  parameter int RESET_OFS = 7
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             ld_n,
  input  logic             rt_n,
  input  logic             sync_mode,
  output logic [WIDTH-1:0] dout,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             aempty_n,
  output logic             afull_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic             wrst_n, rrst_n;
  logic [PW-1:0]    w_ptr_bin, w_gray, w_gray_rs;
  logic [PW-1:0]    r_ptr_bin, r_gray, r_gray_ws;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr, mem_raddr, ne_ofs, nf_ofs;
  logic [WIDTH-1:0] mem_rdata;

  fifo_cdc_sync #(.W(1), .STAGES(2)) u_wrst (
    .clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  fifo_cdc_sync #(.W(1), .STAGES(2)) u_rrst (
    .clk(rclk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  fifo_cdc_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(r_gray), .q(r_gray_ws));
  fifo_cdc_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(w_gray), .q(w_gray_rs));

  fifo_mem #(.W(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
    .raddr(mem_raddr), .rdata(mem_rdata));

  fifo_wside #(.W(WIDTH), .DEPTH(DEPTH), .RESET_OFS(RESET_OFS)) u_w (
    .clk(wclk), .rst_n(wrst_n), .wr_n(wr_n), .ld_n(ld_n), .din(din),
    .sync_mode(sync_mode), .rgray_sync(r_gray_ws), .rptr_live(r_ptr_bin),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .wptr(w_ptr_bin), .wgray(w_gray),
    .full_n(full_n), .half_n(half_n), .afull_n(afull_n),
    .ne_ofs(ne_ofs), .nf_ofs(nf_ofs));

  fifo_rside #(.W(WIDTH), .DEPTH(DEPTH)) u_r (
    .clk(rclk), .rst_n(rrst_n), .rd_n(rd_n), .ld_n(ld_n), .rt_n(rt_n),
    .sync_mode(sync_mode), .wgray_sync(w_gray_rs), .wptr_live(w_ptr_bin),
    .mem_rdata(mem_rdata), .ne_ofs(ne_ofs), .nf_ofs(nf_ofs),
    .mem_raddr(mem_raddr), .rptr(r_ptr_bin), .rgray(r_gray),
    .dout(dout), .empty_n(empty_n), .aempty_n(aempty_n));
endmodule

// File: rtl/prog_flag_fifo_chk.sv
module prog_flag_fifo_chk #(
  parameter int PW = 12
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          ld_n,
  input logic          rt_n,
  input logic          full_n,
  input logic          half_n,
  input logic          empty_n,
  input logic [PW-1:0] w_ptr,
  input logic [PW-1:0] r_ptr
);
  // R1: the write pointer only ever advances by one
  a_r1_wptr_step: assert property (@(posedge wclk) disable iff (!rst_n)
    (w_ptr != $past(w_ptr)) |-> (w_ptr == $past(w_ptr) + 1'b1));

  a_r2_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_n && ld_n && !full_n) |=> $stable(w_ptr));

  a_r3_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_n && ld_n && rt_n && !empty_n) |=> $stable(r_ptr));

  a_r5_full_is_half: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !half_n);

  a_r8_load_keeps_wptr: assert property (@(posedge wclk) disable iff (!rst_n)
    !ld_n |=> $stable(w_ptr));

  a_r9_load_keeps_rptr: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ld_n && rt_n) |=> $stable(r_ptr));

  a_r10_rewind: assert property (@(posedge rclk) disable iff (!rst_n)
    !rt_n |=> (r_ptr == '0));
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
  .ld_n(ld_n), .rt_n(rt_n), .full_n(full_n), .half_n(half_n),
  .empty_n(empty_n), .w_ptr(w_ptr_bin), .r_ptr(r_ptr_bin));

// File: tb/sim_prog_flag_fifo.sv
`timescale 1ns/1ps
module sim_prog_flag_fifo;
  localparam int DEP = 16;

  logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [17:0] din = '0;
  logic        wr_n = 1'b1, rd_n = 1'b1, ld_n = 1'b1, rt_n = 1'b1, sync_mode = 1'b1;
  logic [17:0] dout;
  logic        empty_n, full_n, half_n, aempty_n, afull_n;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  int ne_off  = 7;
  int nf_off  = 7;

  always #10 wclk = ~wclk;
  always #13 rclk = ~rclk;

  prog_flag_fifo #(.WIDTH(18), .DEPTH(DEP), .RESET_OFS(7)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din), .wr_n(wr_n),
    .rd_n(rd_n), .ld_n(ld_n), .rt_n(rt_n), .sync_mode(sync_mode),
    .dout(dout), .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
    .aempty_n(aempty_n), .afull_n(afull_n));

  function automatic logic [17:0] val(int k);
    return 18'((k * 37 + 5) ^ 18'h2AAAA);
  endfunction

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (3) @(negedge wclk);
  endtask

  task automatic wr_word(logic [17:0] v, logic ld);
    @(negedge wclk); wr_n = 1'b0; ld_n = ld; din = v;
    @(negedge wclk); wr_n = 1'b1; ld_n = 1'b1;
  endtask

  task automatic rd_word(logic ld, output logic [17:0] v);
    @(negedge rclk); rd_n = 1'b0; ld_n = ld;
    @(negedge rclk); rd_n = 1'b1; ld_n = 1'b1;
    v = dout;
  endtask

  task automatic chk_flags(int n, string tag);
    chk({tag, " R4 empty_n"}, 18'(empty_n), 18'(n != 0));
    chk({tag, " R4 full_n"},  18'(full_n),  18'(n != DEP));
    chk({tag, " R5 half_n"},  18'(half_n),  18'(!(n > DEP / 2)));
    chk({tag, " R6 aempty_n"}, 18'(aempty_n), 18'(!(n <= ne_off)));
    chk({tag, " R6 afull_n"},  18'(afull_n),  18'(!((DEP - n) <= nf_off)));
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [17:0] v;
    logic [17:0] last;
    repeat (4) @(negedge wclk);
    rst_n = 1'b1;
    settle();
    // R11 reset state
    chk("R11 dout", dout, 18'h0);
    chk_flags(0, "R11");

    // R9 default offsets read back in order
    rd_word(1'b0, v); chk("R9 default near-empty ofs", v, 18'd7);
    rd_word(1'b0, v); chk("R9 default near-full ofs", v, 18'd7);

    // R8 load offsets, R9 read back
    wr_word(18'd3, 1'b0);
    wr_word(18'd5, 1'b0);
    ne_off = 3; nf_off = 5;
    rd_word(1'b0, v); chk("R8 near-empty ofs", v, 18'd3);
    rd_word(1'b0, v); chk("R8 near-full ofs", v, 18'd5);
    settle();
    chk("R8 load leaves fifo empty", 18'(empty_n), 18'd0);

    // R1/R4/R5/R6/R7 sweep every level, alternating flag mode
    for (int n = 1; n <= DEP; n++) begin
      wr_word(val(n - 1), 1'b1);
      sync_mode = n[0];
      settle();
      chk_flags(n, n[0] ? "R7 sync" : "R7 async");
    end
    sync_mode = 1'b1;

    // R2 write while full is dropped
    wr_word(18'h3FFFF, 1'b1);
    settle();
    chk("R2 still full", 18'(full_n), 18'd0);

    // R8 offset load while full, R9 read-back while holding data
    wr_word(18'd4, 1'b0);
    wr_word(18'd6, 1'b0);
    ne_off = 4; nf_off = 6;
    rd_word(1'b0, v); chk("R8 load at full ne", v, 18'd4);
    rd_word(1'b0, v); chk("R9 readback at full nf", v, 18'd6);
    settle();
    chk_flags(DEP, "R6 new offsets");

    // R1/R9 drain in order, pointer untouched by read-back
    for (int k = 0; k < DEP; k++) begin
      rd_word(1'b1, v);
      chk("R1 drain order", v, val(k));
    end
    last = val(DEP - 1);
    settle();
    chk_flags(0, "R2 drained");

    // R3 read while empty holds dout
    rd_word(1'b1, v);
    chk("R3 empty read holds", v, last);

    // R10 retransmit together with a read: rewind wins, dout holds
    @(negedge rclk); rt_n = 1'b0; rd_n = 1'b0;
    @(negedge rclk); rt_n = 1'b1; rd_n = 1'b1;
    chk("R10 dout holds on rewind", dout, last);
    settle();
    chk("R10 not empty after rewind", 18'(empty_n), 18'd1);
    for (int k = 0; k < DEP; k++) begin
      rd_word(1'b1, v);
      chk("R10 replay order", v, val(k));
    end
    settle();
    chk("R4 empty after replay", 18'(empty_n), 18'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule